// File: doc/BRIEF.md
# Banked Shadow General Register File

This block holds the general registers of a processor core as several complete banks of 32 registers each. A current-bank selector picks the bank that ordinary instruction traffic uses: two combinational read ports and one write port. A second selector names the previous bank. Two cross-bank transfer operations use it. The first, fetch-from-previous, reads a register of the previous bank, adds a sign-extended 16-bit offset and writes the sum into the current bank. The second, store-to-previous, copies a register of the current bank into the previous bank.

Register 0 is real storage in every bank and is not forced to zero on read. Ordinary writes to it are always dropped. Store-to-previous may still write it, so software that sets up a bank can also make that bank's register 0 nonzero. The cross-bank transfers depend on a build-time option for an external interrupt controller and on the privilege level. The block reports an illegal-instruction fault or a privilege fault for a transfer that may not run. A faulted transfer changes no register. Instruction fetch, decode, the ALU and the logic that moves the bank selectors on interrupt entry all sit outside the block.

Top module: `shadow_gpr_bank`

## Requirements
- R1: After reset every register of every bank reads as zero.
- R2: An ordinary write updates register `wr_addr` of the current bank on the rising clock edge. A read of the same register in the same cycle returns the old value.
- R3: Banks are independent. A write into one bank leaves the same register index in every other bank unchanged.
- R4: An ordinary write to register 0 is discarded in every bank. A read of register 0 returns the stored bank contents and is not forced to zero.
- R5: Fetch-from-previous writes previous-bank register `rdp_src` plus the sign-extended 16-bit `rdp_imm` into current-bank register `rdp_dst`. A destination of 0 is discarded.
- R6: Store-to-previous copies current-bank register `wrp_src` into previous-bank register `wrp_dst`. Register 0 is a valid destination.
- R7: When the interrupt-controller option is off (`HAS_EIC`=0), any cross-bank request raises `fault_illegal` in the same cycle. `fault_priv` stays low and no register changes.
- R8: When the option is on and `user_mode` is 1, any cross-bank request raises `fault_priv` in the same cycle. `fault_illegal` stays low and no register changes.
- R9: An accepted transfer takes the write path for its cycle, so an ordinary write in that cycle is dropped. If both transfer requests are raised together, fetch-from-previous runs and store-to-previous is ignored. A faulted transfer does not block an ordinary write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_set | input | SET_W | Current bank index |
| prev_set | input | SET_W | Previous bank index |
| user_mode | input | 1 | Core runs at user privilege |
| rd_a_addr | input | ADDR_W | Read port A register index |
| rd_a_data | output | DATA_W | Read port A data, current bank |
| rd_b_addr | input | ADDR_W | Read port B register index |
| rd_b_data | output | DATA_W | Read port B data, current bank |
| wr_en | input | 1 | Ordinary write enable |
| wr_addr | input | ADDR_W | Ordinary write register index |
| wr_data | input | DATA_W | Ordinary write data |
| rdp_req | input | 1 | Fetch-from-previous request |
| rdp_src | input | ADDR_W | Source register in previous bank |
| rdp_imm | input | IMM_W | Signed offset added to the source |
| rdp_dst | input | ADDR_W | Destination register in current bank |
| wrp_req | input | 1 | Store-to-previous request |
| wrp_src | input | ADDR_W | Source register in current bank |
| wrp_dst | input | ADDR_W | Destination register in previous bank |
| fault_illegal | output | 1 | Transfer refused: option not built |
| fault_priv | output | 1 | Transfer refused: user privilege |

## Verification
The bench builds two copies side by side. Both receive the same stimulus. One has four banks with the interrupt-controller option on. The other has two banks with the option off. The four-bank copy allows transfers between distinct banks and between a bank and itself. It also covers negative and positive offsets and the privilege fault. The two-bank copy shows the illegal fault, and shows that its banks stay unchanged while the other copy accepts the same transfer.

// File: rtl/shadow_gpr_pkg.sv
package shadow_gpr_pkg;

   // Index width of the register field in an instruction word.
   localparam int unsigned GPR_IDX_W = 5;

   // Which requester owns the single storage write path in a cycle.
   typedef enum logic [1:0] {
      WSRC_NONE   = 2'd0,
      WSRC_NORMAL = 2'd1,
      WSRC_FETCHP = 2'd2,
      WSRC_STOREP = 2'd3
   } wsrc_e;

endpackage

// File: rtl/sgpr_storage.sv
module sgpr_storage #(
   parameter int unsigned NUM_SETS = 4,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned NUM_RD   = 4,
   localparam int unsigned SET_W   = $clog2(NUM_SETS),
   localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              we,
   input  logic [SET_W-1:0]                  wset,
   input  logic [ADDR_W-1:0]                 waddr,
   input  logic [DATA_W-1:0]                 wdata,
   input  logic [NUM_RD-1:0][SET_W-1:0]      rset,
   input  logic [NUM_RD-1:0][ADDR_W-1:0]     raddr,
   output logic [NUM_RD-1:0][DATA_W-1:0]     rdata
);

   logic [NUM_SETS-1:0][NUM_REGS-1:0][DATA_W-1:0] bank_view;

   // One bank of flops per register set; register 0 is ordinary storage.
   for (genvar s = 0; s < NUM_SETS; s++) begin : g_bank
      logic [NUM_REGS-1:0][DATA_W-1:0] bank_q;
      logic                            bank_we;

      assign bank_we = we && (wset == SET_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bank_q <= '0;
         end else if (bank_we) begin
            bank_q[waddr] <= wdata;
         end
      end

      assign bank_view[s] = bank_q;
   end

   // Combinational read ports, each with its own bank selector.
   for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
      assign rdata[p] = bank_view[rset[p]][raddr[p]];
   end

endmodule

// File: rtl/sgpr_xfer_ctrl.sv
module sgpr_xfer_ctrl
   import shadow_gpr_pkg::*;
#(
   parameter int unsigned SET_W   = 2,
   parameter int unsigned ADDR_W  = 5,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned IMM_W   = 16,
   parameter bit          HAS_EIC = 1'b1
) (
   input  logic [SET_W-1:0]  cur_set,
   input  logic [SET_W-1:0]  prev_set,
   input  logic              user_mode,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rdp_req,
   input  logic [DATA_W-1:0] rdp_src_val,
   input  logic [IMM_W-1:0]  rdp_imm,
   input  logic [ADDR_W-1:0] rdp_dst,
   input  logic              wrp_req,
   input  logic [DATA_W-1:0] wrp_src_val,
   input  logic [ADDR_W-1:0] wrp_dst,
   output logic              we,
   output logic [SET_W-1:0]  wset,
   output logic [ADDR_W-1:0] waddr,
   output logic [DATA_W-1:0] wdata,
   output logic              fault_illegal,
   output logic              fault_priv
);

   localparam int unsigned EXT_W = DATA_W - IMM_W;

   logic              xfer_any;
   logic              xfer_ok;
   logic [DATA_W-1:0] imm_ext;
   wsrc_e             wsrc;

   assign xfer_any = rdp_req | wrp_req;
   assign imm_ext  = {{EXT_W{rdp_imm[IMM_W-1]}}, rdp_imm};

   // Fault policy picked by the interrupt-controller build option.
   if (HAS_EIC) begin : g_eic
      assign fault_illegal = 1'b0;
      assign fault_priv    = xfer_any & user_mode;
   end else begin : g_no_eic
      logic unused_priv;
      assign unused_priv   = user_mode;
      assign fault_illegal = xfer_any;
      assign fault_priv    = 1'b0;
   end

   assign xfer_ok = xfer_any & ~fault_illegal & ~fault_priv;

   // Arbitration: fetch-from-previous, then store-to-previous, then normal.
   always_comb begin
      if (xfer_ok && rdp_req) begin
         wsrc = WSRC_FETCHP;
      end else if (xfer_ok && wrp_req) begin
         wsrc = WSRC_STOREP;
      end else if (wr_en) begin
         wsrc = WSRC_NORMAL;
      end else begin
         wsrc = WSRC_NONE;
      end
   end

   always_comb begin
      we    = 1'b0;
      wset  = cur_set;
      waddr = wr_addr;
      wdata = wr_data;
      unique case (wsrc)
         WSRC_FETCHP: begin
            we    = (rdp_dst != '0);
            waddr = rdp_dst;
            wdata = rdp_src_val + imm_ext;
         end
         WSRC_STOREP: begin
            we    = 1'b1;
            wset  = prev_set;
            waddr = wrp_dst;
            wdata = wrp_src_val;
         end
         WSRC_NORMAL: begin
            we    = (wr_addr != '0);
         end
         default: begin
            we    = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/shadow_gpr_bank.sv
module shadow_gpr_bank #(
   parameter int unsigned NUM_SETS = 4,
   parameter int unsigned NUM_REGS = 32,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned IMM_W    = 16,
   parameter bit          HAS_EIC  = 1'b1,
   localparam int unsigned SET_W   = $clog2(NUM_SETS),
   localparam int unsigned ADDR_W  = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SET_W-1:0]  cur_set,
   input  logic [SET_W-1:0]  prev_set,
   input  logic              user_mode,
   input  logic [ADDR_W-1:0] rd_a_addr,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [ADDR_W-1:0] rd_b_addr,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rdp_req,
   input  logic [ADDR_W-1:0] rdp_src,
   input  logic [IMM_W-1:0]  rdp_imm,
   input  logic [ADDR_W-1:0] rdp_dst,
   input  logic              wrp_req,
   input  logic [ADDR_W-1:0] wrp_src,
   input  logic [ADDR_W-1:0] wrp_dst,
   output logic              fault_illegal,
   output logic              fault_priv
);

   // Read port map: 0 and 1 serve the instruction, 2 the previous-bank
   // source of a fetch, 3 the current-bank source of a store.
   localparam int unsigned NUM_RD  = 4;
   localparam int unsigned RP_A    = 0;
   localparam int unsigned RP_B    = 1;
   localparam int unsigned RP_PREV = 2;
   localparam int unsigned RP_CUR  = 3;

   if (NUM_SETS < 2) begin : g_chk_sets
      $error("shadow_gpr_bank: NUM_SETS must be at least 2");
   end
   if (NUM_REGS < 2) begin : g_chk_regs
      $error("shadow_gpr_bank: NUM_REGS must be at least 2");
   end
   if (DATA_W <= IMM_W) begin : g_chk_imm
      $error("shadow_gpr_bank: DATA_W must exceed IMM_W");
   end

   logic [NUM_RD-1:0][SET_W-1:0]  rd_set;
   logic [NUM_RD-1:0][ADDR_W-1:0] rd_idx;
   logic [NUM_RD-1:0][DATA_W-1:0] rd_val;

   logic              stor_we;
   logic [SET_W-1:0]  stor_wset;
   logic [ADDR_W-1:0] stor_waddr;
   logic [DATA_W-1:0] stor_wdata;

   assign rd_set[RP_A]    = cur_set;
   assign rd_idx[RP_A]    = rd_a_addr;
   assign rd_set[RP_B]    = cur_set;
   assign rd_idx[RP_B]    = rd_b_addr;
   assign rd_set[RP_PREV] = prev_set;
   assign rd_idx[RP_PREV] = rdp_src;
   assign rd_set[RP_CUR]  = cur_set;
   assign rd_idx[RP_CUR]  = wrp_src;

   assign rd_a_data = rd_val[RP_A];
   assign rd_b_data = rd_val[RP_B];

   sgpr_storage #(
      .NUM_SETS (NUM_SETS),
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W),
      .NUM_RD   (NUM_RD)
   ) u_storage (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (stor_we),
      .wset  (stor_wset),
      .waddr (stor_waddr),
      .wdata (stor_wdata),
      .rset  (rd_set),
      .raddr (rd_idx),
      .rdata (rd_val)
   );

   sgpr_xfer_ctrl #(
      .SET_W   (SET_W),
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .IMM_W   (IMM_W),
      .HAS_EIC (HAS_EIC)
   ) u_ctrl (
      .cur_set       (cur_set),
      .prev_set      (prev_set),
      .user_mode     (user_mode),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .rdp_req       (rdp_req),
      .rdp_src_val   (rd_val[RP_PREV]),
      .rdp_imm       (rdp_imm),
      .rdp_dst       (rdp_dst),
      .wrp_req       (wrp_req),
      .wrp_src_val   (rd_val[RP_CUR]),
      .wrp_dst       (wrp_dst),
      .we            (stor_we),
      .wset          (stor_wset),
      .waddr         (stor_waddr),
      .wdata         (stor_wdata),
      .fault_illegal (fault_illegal),
      .fault_priv    (fault_priv)
   );

endmodule

// File: rtl/sgpr_checker.sv
module sgpr_checker #(
   parameter int unsigned SET_W   = 2,
   parameter int unsigned ADDR_W  = 5,
   parameter bit          HAS_EIC = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [SET_W-1:0]  cur_set,
   input logic [SET_W-1:0]  prev_set,
   input logic              user_mode,
   input logic              wr_en,
   input logic              rdp_req,
   input logic [ADDR_W-1:0] rdp_dst,
   input logic              wrp_req,
   input logic [ADDR_W-1:0] wrp_dst,
   input logic              fault_illegal,
   input logic              fault_priv,
   input logic              stor_we,
   input logic [SET_W-1:0]  stor_wset,
   input logic [ADDR_W-1:0] stor_waddr
);

   logic accepted;
   assign accepted = (rdp_req || wrp_req) && !fault_illegal && !fault_priv;

   // R7
   illegal_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_illegal |-> (!HAS_EIC && (rdp_req || wrp_req)));

   // R8
   priv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_priv |-> (HAS_EIC && user_mode && (rdp_req || wrp_req)));

   // R7
   fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fault_illegal && fault_priv));

   // R8
   faulted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((fault_priv || fault_illegal) && !wr_en) |-> !stor_we);

   // R4
   r0_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stor_we && stor_waddr == '0) |-> (accepted && wrp_req && !rdp_req));

   // R6
   wrp_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && wrp_req && !rdp_req) |->
         (stor_we && stor_wset == prev_set && stor_waddr == wrp_dst));

   // R9
   rdp_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && rdp_req && rdp_dst != '0) |->
         (stor_we && stor_wset == cur_set && stor_waddr == rdp_dst));

endmodule

bind shadow_gpr_bank sgpr_checker #(
   .SET_W   (SET_W),
   .ADDR_W  (ADDR_W),
   .HAS_EIC (HAS_EIC)
) u_sgpr_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cur_set       (cur_set),
   .prev_set      (prev_set),
   .user_mode     (user_mode),
   .wr_en         (wr_en),
   .rdp_req       (rdp_req),
   .rdp_dst       (rdp_dst),
   .wrp_req       (wrp_req),
   .wrp_dst       (wrp_dst),
   .fault_illegal (fault_illegal),
   .fault_priv    (fault_priv),
   .stor_we       (stor_we),
   .stor_wset     (stor_wset),
   .stor_waddr    (stor_waddr)
);

// File: tb/shadow_gpr_bank_bench.sv
`timescale 1ns/1ps
module shadow_gpr_bank_bench;

   typedef struct {
      int          cyc;
      int          port;
      logic [31:0] exp;
      string       tag;
   } item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cur_set = '0;
   logic [1:0]  prev_set = '0;
   logic        user_mode = 1'b0;
   logic [4:0]  rd_a_addr = '0;
   logic [4:0]  rd_b_addr = '0;
   logic        wr_en = 1'b0;
   logic [4:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        rdp_req = 1'b0;
   logic [4:0]  rdp_src = '0;
   logic [15:0] rdp_imm = '0;
   logic [4:0]  rdp_dst = '0;
   logic        wrp_req = 1'b0;
   logic [4:0]  wrp_src = '0;
   logic [4:0]  wrp_dst = '0;

   logic [31:0] rd_a_data, rd_b_data, n_rd_a_data, n_rd_b_data;
   logic        fault_illegal, fault_priv, n_fault_illegal, n_fault_priv;

   int          cyc = 0;
   int          n_cmp = 0;
   int          n_bad = 0;
   item_t       sbq[$];
   item_t       it;
   logic [31:0] act;

   logic [31:0] mm [4][32];
   logic [31:0] mn [2][32];

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   shadow_gpr_bank #(.NUM_SETS(4), .HAS_EIC(1'b1)) u_shadow_gpr_bank (
      .clk(clk), .rst_n(rst_n), .cur_set(cur_set), .prev_set(prev_set),
      .user_mode(user_mode), .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
      .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rdp_req(rdp_req),
      .rdp_src(rdp_src), .rdp_imm(rdp_imm), .rdp_dst(rdp_dst),
      .wrp_req(wrp_req), .wrp_src(wrp_src), .wrp_dst(wrp_dst),
      .fault_illegal(fault_illegal), .fault_priv(fault_priv));

   shadow_gpr_bank #(.NUM_SETS(2), .HAS_EIC(1'b0)) u_shadow_gpr_bank_noeic (
      .clk(clk), .rst_n(rst_n), .cur_set(cur_set[0]), .prev_set(prev_set[0]),
      .user_mode(user_mode), .rd_a_addr(rd_a_addr), .rd_a_data(n_rd_a_data),
      .rd_b_addr(rd_b_addr), .rd_b_data(n_rd_b_data), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rdp_req(rdp_req),
      .rdp_src(rdp_src), .rdp_imm(rdp_imm), .rdp_dst(rdp_dst),
      .wrp_req(wrp_req), .wrp_src(wrp_src), .wrp_dst(wrp_dst),
      .fault_illegal(n_fault_illegal), .fault_priv(n_fault_priv));

   function automatic logic [31:0] pick(int port);
      case (port)
         0: return rd_a_data;
         1: return rd_b_data;
         2: return {31'd0, fault_illegal};
         3: return {31'd0, fault_priv};
         4: return {31'd0, n_fault_illegal};
         5: return {31'd0, n_fault_priv};
         default: return n_rd_a_data;
      endcase
   endfunction

   // Monitor: compares queued expectations in the middle of their cycle.
   always @(negedge clk) begin
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
         it  = sbq.pop_front();
         act = pick(it.port);
         n_cmp++;
         if (it.cyc != cyc || act !== it.exp) begin
            n_bad++;
            $display("FAIL %s (port %0d): actual %h expected %h", it.tag, it.port, act, it.exp);
         end
      end
   end

   task automatic push(int port, logic [31:0] exp, string tag);
      item_t e;
      e.cyc = cyc; e.port = port; e.exp = exp; e.tag = tag;
      sbq.push_back(e);
   endtask

   task automatic tick_begin();
      @(posedge clk);
      #1;
      wr_en = 1'b0; rdp_req = 1'b0; wrp_req = 1'b0; user_mode = 1'b0;
   endtask

   task automatic normal_wr(int s, int r, logic [31:0] d, string tag);
      tick_begin();
      cur_set = 2'(s); wr_en = 1'b1; wr_addr = 5'(r); wr_data = d;
      rd_a_addr = 5'(r);
      push(0, mm[s][r], {tag, " same-cycle read"});
      if (r != 0) begin
         mm[s][r] = d;
         mn[s % 2][r] = d;
      end
   endtask

   task automatic read2(int s, int a, int b, string tag);
      tick_begin();
      cur_set = 2'(s); rd_a_addr = 5'(a); rd_b_addr = 5'(b);
      push(0, mm[s][a], {tag, " port A"});
      push(1, mm[s][b], {tag, " port B"});
      push(6, mn[s % 2][a], {tag, " option-off copy"});
   endtask

   task automatic xfer(bit do_rd, bit do_wr, int cs, int ps,
                       int rsrc, logic [15:0] imm, int rdst,
                       int wsrc, int wdst, bit user,
                       bit nwr, int naddr, logic [31:0] ndata, string tag);
      bit          any;
      bit          acc;
      logic [31:0] sum;
      logic [31:0] cpy;
      tick_begin();
      cur_set = 2'(cs); prev_set = 2'(ps); user_mode = user;
      rdp_req = do_rd; rdp_src = 5'(rsrc); rdp_imm = imm; rdp_dst = 5'(rdst);
      wrp_req = do_wr; wrp_src = 5'(wsrc); wrp_dst = 5'(wdst);
      wr_en = nwr; wr_addr = 5'(naddr); wr_data = ndata;
      any = do_rd | do_wr;
      acc = any & ~user;
      push(2, 32'd0, {tag, " R7 illegal, option on"});
      push(3, {31'd0, any & user}, {tag, " R8 priv, option on"});
      push(4, {31'd0, any}, {tag, " R7 illegal, option off"});
      push(5, 32'd0, {tag, " R7 priv, option off"});
      sum = mm[ps][rsrc] + {{16{imm[15]}}, imm};
      cpy = mm[cs][wsrc];
      if (acc && do_rd) begin
         if (rdst != 0) mm[cs][rdst] = sum;
      end else if (acc && do_wr) begin
         mm[ps][wdst] = cpy;
      end else if (nwr && naddr != 0) begin
         mm[cs][naddr] = ndata;
      end
      if (nwr && naddr != 0) mn[cs % 2][naddr] = ndata;
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(4 * 20000);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung run expected completion");
      summary();
   end

   initial begin
      for (int s = 0; s < 4; s++)
         for (int r = 0; r < 32; r++) mm[s][r] = '0;
      for (int s = 0; s < 2; s++)
         for (int r = 0; r < 32; r++) mn[s][r] = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: everything clear after reset
      read2(0, 1, 31, "R1 bank0");
      read2(3, 5, 0, "R1 bank3");
      read2(1, 17, 2, "R1 bank1");

      // R2: write lands at the edge, same-cycle read sees old data
      normal_wr(0, 5, 32'hA5A5_0001, "R2 write b0 r5");
      read2(0, 5, 0, "R2 readback b0 r5");

      // R3: banks independent
      normal_wr(1, 5, 32'h0000_1111, "R3 write b1 r5");
      read2(1, 5, 0, "R3 b1 r5");
      read2(0, 5, 1, "R3 b0 r5 kept");
      read2(2, 5, 0, "R3 b2 r5 untouched");

      // R4: ordinary writes to register 0 are dropped
      normal_wr(0, 0, 32'hFFFF_FFFF, "R4 write b0 r0");
      read2(0, 0, 5, "R4 b0 r0 still zero");
      normal_wr(2, 0, 32'h0000_1234, "R4 write b2 r0");
      read2(2, 0, 5, "R4 b2 r0 still zero");

      // R6: store-to-previous, including register 0 of the target
      xfer(0, 1, 0, 2, 0, 16'h0, 0, 5, 0, 0, 0, 0, 0, "R6 store b0.r5->b2.r0");
      read2(2, 0, 1, "R6 R4 b2 r0 reads stored value");
      xfer(0, 1, 1, 3, 0, 16'h0, 0, 5, 7, 0, 0, 0, 0, "R6 store b1.r5->b3.r7");
      read2(3, 7, 0, "R6 b3 r7");

      // R5: fetch-from-previous with negative, positive offset and r0 target
      xfer(1, 0, 0, 3, 7, 16'hFFFE, 9, 0, 0, 0, 0, 0, 0, "R5 fetch b3.r7-2");
      read2(0, 9, 7, "R5 b0 r9 = 0x110F");
      xfer(1, 0, 1, 2, 0, 16'h7FFF, 3, 0, 0, 0, 0, 0, 0, "R5 fetch b2.r0+7FFF");
      read2(1, 3, 0, "R5 b1 r3");
      xfer(1, 0, 0, 3, 7, 16'h0005, 0, 0, 0, 0, 0, 0, 0, "R5 fetch to r0");
      read2(0, 0, 9, "R5 b0 r0 unchanged");

      // R8: user mode refuses both transfers
      xfer(0, 1, 0, 1, 0, 16'h0, 0, 5, 8, 1, 0, 0, 0, "R8 user store");
      read2(1, 8, 5, "R8 b1 r8 untouched");
      xfer(1, 0, 0, 3, 7, 16'h0001, 10, 0, 0, 1, 0, 0, 0, "R8 user fetch");
      read2(0, 10, 9, "R8 b0 r10 untouched");

      // R7: option off refuses; option on accepts the same request
      xfer(0, 1, 0, 1, 0, 16'h0, 0, 5, 12, 0, 0, 0, 0, "R7 store b0.r5->b1.r12");
      read2(1, 12, 0, "R7 b1 r12");

      // R9: accepted transfer displaces ordinary write
      xfer(0, 1, 0, 2, 0, 16'h0, 0, 5, 11, 0, 1, 11, 32'h0000_BEEF, "R9 store vs write");
      read2(0, 11, 0, "R9 b0 r11");
      read2(2, 11, 0, "R9 b2 r11");
      // R9: fetch wins over store when both requested
      xfer(1, 1, 0, 3, 7, 16'h0, 14, 5, 15, 0, 0, 0, 0, "R9 both requests");
      read2(0, 14, 0, "R9 b0 r14 from fetch");
      read2(3, 15, 7, "R9 b3 r15 store ignored");
      // R9: faulted transfer lets the ordinary write through
      xfer(0, 1, 0, 1, 0, 16'h0, 0, 5, 13, 1, 1, 13, 32'h0000_0077, "R9 faulted with write");
      read2(0, 13, 0, "R9 b0 r13 written");

      tick_begin();
      repeat (3) @(posedge clk);
      if (sbq.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: actual %0d items left expected 0", sbq.size());
      end
      summary();
   end

endmodule